// File: doc/BRIEF.md
# Masked SIMD Lane Population Counter

This unit takes a 512-bit source vector and, for every element, produces the number of bits set to one in that element. The element width is chosen per operation: 8, 16, 32 or 64 bits. The active vector length is also chosen per operation: 128, 256 or 512 bits. Each count is zero-extended to fill its own element.

A writemask selects which lanes receive a fresh count. The other lanes either keep the old destination value (merge mode) or become zero (zero mode). For 32-bit and 64-bit elements, a broadcast flag makes every lane count element 0 of the source. Everything above the active length is cleared.

The result is registered, so it appears one clock after the input strobe. Between operations the last result is held.

Top module: `simd_popcnt_unit`

## Requirements
- R1: `esize_i` selects the element width: 2'b00 gives 8 bits, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64. Each lane's result is the count of ones in that lane, zero-extended to the element width (largest values 8, 16, 32, 64).
- R2: `vlen_i` selects the active length: 2'b00 gives 128 bits, 2'b01 gives 256, and 2'b10 or 2'b11 gives 512. All result bits from the active length up to bit 511 are zero, whatever the mask.
- R3: When `mask_en_i` is 0, every active lane is computed and `mask_i` is ignored.
- R4: When `mask_en_i` is 1, lane j (counted from bit 0 upward) is computed only if `mask_i[j]` is 1. Mask bits at or above the active lane count have no effect.
- R5: In merge mode (`zero_mode_i` = 0), an active lane whose mask bit is 0 takes its value from the same bits of `dst_old_i`.
- R6: In zero mode (`zero_mode_i` = 1), an active lane whose mask bit is 0 becomes zero.
- R7: When `bcast_i` is 1 and the element width is 32 or 64 bits, every computed lane counts source element 0 instead of its own element.
- R8: When the element width is 8 or 16 bits, `bcast_i` has no effect.
- R9: `out_vld_o` is `in_vld_i` delayed by one clock. `res_o` takes a new value only in the cycle after `in_vld_i` = 1, and otherwise holds. After reset, `out_vld_o` and `res_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld_i | input | 1 | Operation strobe |
| src_i | input | 512 | Source vector |
| dst_old_i | input | 512 | Prior destination value, used for merging |
| mask_i | input | 64 | Per-lane writemask, bit j for lane j |
| mask_en_i | input | 1 | 1 applies the writemask, 0 enables all lanes |
| zero_mode_i | input | 1 | 1 zeroes masked lanes, 0 merges them |
| bcast_i | input | 1 | Broadcast element 0 (32/64-bit widths only) |
| esize_i | input | 2 | Element width code |
| vlen_i | input | 2 | Active vector length code |
| out_vld_o | output | 1 | Result valid, one cycle after the strobe |
| res_o | output | 512 | Result vector |

## Verification
Several functions can act on the same lane in one operation. Broadcast can coincide with merge or zero masking, so a lane may hold an old value while its neighbour counts element 0. Clearing above a short active length can coincide with mask bits that are set beyond the lane count. Random operations mix all four widths, all length codes, broadcast, mask enable and both masking modes; directed cases pin the extreme counts and the empty mask. Every result is compared bit for bit with a per-lane model in the bench.

// File: rtl/popcnt_pkg.sv
package popcnt_pkg;

    typedef enum logic [1:0] {
        ESZ_BYTE  = 2'b00,
        ESZ_WORD  = 2'b01,
        ESZ_DWORD = 2'b10,
        ESZ_QWORD = 2'b11
    } esize_e;

    typedef enum logic [1:0] {
        VL_128  = 2'b00,
        VL_256  = 2'b01,
        VL_512  = 2'b10,
        VL_512X = 2'b11
    } vlen_e;

    // ones in one byte, small adder chain
    function automatic logic [3:0] ones8(input logic [7:0] v);
        logic [3:0] s;
        s = '0;
        for (int i = 0; i < 8; i++) begin
            s = s + {3'b000, v[i]};
        end
        return s;
    endfunction

endpackage

// File: rtl/pc_bcast_src.sv
module pc_bcast_src
    import popcnt_pkg::*;
#(
    parameter int VEC_W = 512
) (
    input  logic [VEC_W-1:0] src_i,
    input  logic             bcast_i,
    input  esize_e           esize_i,
    output logic [VEC_W-1:0] src_o
);
    localparam int N32 = VEC_W / 32;
    localparam int N64 = VEC_W / 64;

    always_comb begin
        src_o = src_i;
        if (bcast_i && esize_i == ESZ_DWORD) begin
            src_o = {N32{src_i[31:0]}};
        end else if (bcast_i && esize_i == ESZ_QWORD) begin
            src_o = {N64{src_i[63:0]}};
        end
    end
endmodule

// File: rtl/pc_count_tree.sv
module pc_count_tree
    import popcnt_pkg::*;
#(
    parameter int VEC_W = 512
) (
    input  logic [VEC_W-1:0] vec_i,
    input  esize_e           esize_i,
    output logic [VEC_W-1:0] cnt_o
);
    localparam int NB = VEC_W / 8;
    localparam int NW = NB / 2;
    localparam int ND = NB / 4;
    localparam int NQ = NB / 8;

    logic [3:0] bc [NB];
    logic [4:0] wc [NW];
    logic [5:0] dc [ND];
    logic [6:0] qc [NQ];

    genvar g;
    for (g = 0; g < NB; g++) begin : g_byte
        assign bc[g] = ones8(vec_i[8*g +: 8]);
    end
    for (g = 0; g < NW; g++) begin : g_word
        assign wc[g] = {1'b0, bc[2*g]} + {1'b0, bc[2*g+1]};
    end
    for (g = 0; g < ND; g++) begin : g_dword
        assign dc[g] = {1'b0, wc[2*g]} + {1'b0, wc[2*g+1]};
    end
    for (g = 0; g < NQ; g++) begin : g_qword
        assign qc[g] = {1'b0, dc[2*g]} + {1'b0, dc[2*g+1]};
    end

    always_comb begin
        cnt_o = '0;
        case (esize_i)
            ESZ_BYTE:  for (int i = 0; i < NB; i++) cnt_o[8*i  +: 8]  = {4'b0, bc[i]};
            ESZ_WORD:  for (int i = 0; i < NW; i++) cnt_o[16*i +: 16] = {11'b0, wc[i]};
            ESZ_DWORD: for (int i = 0; i < ND; i++) cnt_o[32*i +: 32] = {26'b0, dc[i]};
            default:   for (int i = 0; i < NQ; i++) cnt_o[64*i +: 64] = {57'b0, qc[i]};
        endcase
    end
endmodule

// File: rtl/pc_lane_gate.sv
module pc_lane_gate
    import popcnt_pkg::*;
#(
    parameter int VEC_W = 512
) (
    input  esize_e                 esize_i,
    input  vlen_e                  vlen_i,
    input  logic [VEC_W/8-1:0]     mask_i,
    input  logic                   mask_en_i,
    output logic [VEC_W/8-1:0]     act_o,
    output logic [VEC_W/8-1:0]     en_o
);
    localparam int NB     = VEC_W / 8;
    localparam int LIDX_W = $clog2(NB);

    int unsigned          nact;
    logic [LIDX_W-1:0]    lidx;

    always_comb begin
        case (vlen_i)
            VL_128:  nact = 16;
            VL_256:  nact = 32;
            default: nact = NB;
        endcase
        lidx = '0;
        for (int b = 0; b < NB; b++) begin
            act_o[b] = (b < nact);
            lidx     = LIDX_W'(b >> esize_i);
            en_o[b]  = !mask_en_i || mask_i[lidx];
        end
    end
endmodule

// File: rtl/simd_popcnt_unit.sv
module simd_popcnt_unit
    import popcnt_pkg::*;
#(
    parameter int VEC_W = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_vld_i,
    input  logic [VEC_W-1:0]   src_i,
    input  logic [VEC_W-1:0]   dst_old_i,
    input  logic [VEC_W/8-1:0] mask_i,
    input  logic               mask_en_i,
    input  logic               zero_mode_i,
    input  logic               bcast_i,
    input  logic [1:0]         esize_i,
    input  logic [1:0]         vlen_i,
    output logic               out_vld_o,
    output logic [VEC_W-1:0]   res_o
);
    localparam int NB = VEC_W / 8;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] res;
    } st_t;

    st_t st_d, st_q;

    esize_e           esz;
    vlen_e            vl;
    logic [VEC_W-1:0] src_eff;
    logic [VEC_W-1:0] cnt;
    logic [NB-1:0]    act, en;

    assign esz = esize_e'(esize_i);
    assign vl  = vlen_e'(vlen_i);

    pc_bcast_src #(.VEC_W(VEC_W)) u_bcast (
        .src_i   (src_i),
        .bcast_i (bcast_i),
        .esize_i (esz),
        .src_o   (src_eff)
    );

    pc_count_tree #(.VEC_W(VEC_W)) u_tree (
        .vec_i   (src_eff),
        .esize_i (esz),
        .cnt_o   (cnt)
    );

    pc_lane_gate #(.VEC_W(VEC_W)) u_gate (
        .esize_i   (esz),
        .vlen_i    (vl),
        .mask_i    (mask_i),
        .mask_en_i (mask_en_i),
        .act_o     (act),
        .en_o      (en)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld_i;
        if (in_vld_i) begin
            for (int b = 0; b < NB; b++) begin
                if (!act[b])          st_d.res[8*b +: 8] = 8'h00;
                else if (en[b])       st_d.res[8*b +: 8] = cnt[8*b +: 8];
                else if (zero_mode_i) st_d.res[8*b +: 8] = 8'h00;
                else                  st_d.res[8*b +: 8] = dst_old_i[8*b +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld_o = st_q.vld;
    assign res_o     = st_q.res;

    assert_vld_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld_i |=> out_vld_o);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld_i |=> (!out_vld_o && $stable(res_o)));
    assert_tail_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && vlen_i == 2'b00) |=> (res_o[VEC_W-1:128] == '0));
    assert_merge_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && mask_en_i && !zero_mode_i && mask_i == '0 && vlen_i[1])
        |=> (res_o == $past(dst_old_i)));
    assert_zero_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && mask_en_i && zero_mode_i && mask_i == '0) |=> (res_o == '0));
    assert_bcast_same_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && bcast_i && esize_i == 2'b11 && vlen_i[1] && !mask_en_i)
        |=> (res_o[VEC_W-1 -: 64] == res_o[63:0]));
    assert_qword_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && esize_i == 2'b11 && !mask_en_i && (&src_i[63:0]))
        |=> (res_o[63:0] == 64'd64));
endmodule

// File: tb/tb_simd_popcnt_unit.sv
`timescale 1ns/1ps
module tb_simd_popcnt_unit;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_vld;
    logic [511:0] src, old;
    logic [63:0]  mask;
    logic         men, zm, bc;
    logic [1:0]   es, vl;
    logic         out_vld;
    logic [511:0] res;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;
    logic [511:0] last_exp;

    always #4 clk = ~clk;

    simd_popcnt_unit dut (
        .clk(clk), .rst_n(rst_n), .in_vld_i(in_vld), .src_i(src), .dst_old_i(old),
        .mask_i(mask), .mask_en_i(men), .zero_mode_i(zm), .bcast_i(bc),
        .esize_i(es), .vlen_i(vl), .out_vld_o(out_vld), .res_o(res)
    );

    function automatic logic [511:0] model(input logic [511:0] s, input logic [511:0] o,
                                           input logic [63:0] m, input bit me, input bit z,
                                           input bit b, input int e, input int v);
        logic [511:0] r;
        int ew, vbits, nl;
        r     = '0;
        ew    = 8 << e;
        vbits = (v >= 2) ? 512 : (128 << v);
        nl    = vbits / ew;
        for (int j = 0; j < nl; j++) begin
            int base;
            int sb;
            int c;
            logic [63:0] cv;
            base = j * ew;
            sb   = (b && e >= 2) ? 0 : base;
            c    = 0;
            for (int k = 0; k < ew; k++) c += int'(s[sb + k]);
            cv = 64'(c);
            if (!me || m[j]) begin
                for (int k = 0; k < ew; k++) r[base + k] = cv[k];
            end else if (!z) begin
                for (int k = 0; k < ew; k++) r[base + k] = o[base + k];
            end
        end
        return r;
    endfunction

    function automatic logic [511:0] rnd512();
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom;
        return r;
    endfunction

    task automatic check(input string tag, input bit ok, input logic [511:0] act,
                         input logic [511:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: vld=%0b got %h expected %h", tag, out_vld, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic [511:0] s, input logic [511:0] o,
                         input logic [63:0] m, input bit me, input bit z, input bit b,
                         input logic [1:0] e, input logic [1:0] v);
        logic [511:0] exp;
        @(negedge clk);
        src = s; old = o; mask = m; men = me; zm = z; bc = b; es = e; vl = v;
        in_vld = 1'b1;
        exp = model(s, o, m, me, z, b, int'(e), int'(v));
        @(negedge clk);
        in_vld = 1'b0;
        check(tag, out_vld === 1'b1 && res === exp, res, exp);
        last_exp = exp;
    endtask

    initial begin
        #1600000;
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: run hung, got no end expected end");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [511:0] ones, pat;
        void'($urandom(32'h5eed_0a17));
        ones = '1;
        rst_n = 1'b0; in_vld = 1'b0; src = '0; old = '0; mask = '0;
        men = 1'b0; zm = 1'b0; bc = 1'b0; es = 2'b00; vl = 2'b00;
        repeat (3) @(negedge clk);
        check("R9 reset", out_vld === 1'b0 && res === '0, res, '0);
        rst_n = 1'b1;

        // R1 extreme counts per width, no mask, full length
        drive("R1 byte", ones, '0, '0, 0, 0, 0, 2'b00, 2'b10);
        check("R1 byte const", res === {64{8'h08}}, res, {64{8'h08}});
        drive("R1 qword", ones, '0, '0, 0, 0, 0, 2'b11, 2'b10);
        check("R1 qword const", res === {8{64'd64}}, res, {8{64'd64}});
        drive("R1 word", ones, '0, '0, 0, 0, 0, 2'b01, 2'b10);
        drive("R1 dword", rnd512(), '0, '0, 0, 0, 0, 2'b10, 2'b11);
        // R2 tail clearing, merge mode with ones in old
        drive("R2 len128", ones, ones, 64'h0, 1, 0, 0, 2'b00, 2'b00);
        check("R2 tail", res[511:128] === '0, res, last_exp);
        drive("R2 len256", rnd512(), ones, 64'h5555, 1, 0, 0, 2'b01, 2'b01);
        // R3 no writemask with empty mask
        drive("R3 nomask", rnd512(), ones, 64'h0, 0, 1, 0, 2'b00, 2'b10);
        // R4 mask bits above lane count set
        drive("R4 upper mask", rnd512(), ones, 64'hFFFF_FFFF_FFFF_0000, 1, 0, 0, 2'b10, 2'b01);
        // R5 merge and R6 zero
        pat = rnd512();
        drive("R5 merge", rnd512(), pat, 64'hA5, 1, 0, 0, 2'b11, 2'b10);
        drive("R6 zero", rnd512(), pat, 64'h3C, 1, 1, 0, 2'b11, 2'b10);
        // R7 broadcast for dword and qword
        drive("R7 bcast dword", rnd512(), pat, 64'hFFFF, 1, 0, 1, 2'b10, 2'b10);
        drive("R7 bcast qword", rnd512(), pat, 64'h6, 1, 1, 1, 2'b11, 2'b00);
        // R8 broadcast ignored for bytes and words
        drive("R8 bcast byte", rnd512(), pat, '1, 0, 0, 1, 2'b00, 2'b10);
        drive("R8 bcast word", rnd512(), pat, '1, 1, 0, 1, 2'b01, 2'b10);
        // R9 hold while strobe low
        @(negedge clk);
        src = rnd512(); old = rnd512(); mask = '1;
        @(negedge clk);
        check("R9 hold", out_vld === 1'b0 && res === last_exp, res, last_exp);

        for (int n = 0; n < 600; n++) begin
            logic [511:0] s;
            int sel;
            sel = $urandom % 8;
            s = (sel == 0) ? ones : (sel == 1) ? '0 : rnd512();
            drive("R1-R8 random", s, rnd512(), {$urandom, $urandom}, 1'($urandom),
                  1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule